// File: doc/BRIEF.md
# Serial Configuration Register Bank with Staged Updates

This block receives 32-bit configuration words over a three-line serial port (serial clock, serial data and load strobe) and stores them in a bank of five configuration registers. All three serial lines are asynchronous to the system clock. They are brought into the system clock domain through synchronizer chains. Rising edges of the serial clock shift one bit into a 32-bit shift register. A rising edge of the load strobe commits the shift register contents to the register whose index is held in the word's three lowest bits.

Some fields in registers 1 and 2 are staged rather than applied at once. A write to their register only parks the new value. The value reaches the active outputs when register 0 is next written. Because of this, a setting that is split across register 0 and register 1 changes in a single cycle. The main such setting is a 25-bit fractional divider value. The block drives out all five active register words and the assembled fractional value.

Top module: `cfg_serial_regbank`

## Requirements
- R1: Each synchronized rising edge of the serial clock shifts the synchronized data bit into bit 0 of the shift register, so a word sent most significant bit first ends up with its first bit at bit 31.
- R2: The active registers change only in the cycle after a synchronized rising edge of the load strobe. Shifting alone leaves every output unchanged.
- R3: A committed word whose bits [2:0] are 5, 6 or 7 changes no register and no output.
- R4: A committed word with bits [2:0] = 0 replaces the whole of active register 0. This includes the fractional high part at bits [14:3] and the 12-bit integer divide field at bits [26:15].
- R5: For codes 1 to 4, every bit of the committed word outside the staged fields appears at once in the active register that the code selects.
- R6: The staged fields are register 1 bits [15:3] (fractional low part) and, in register 2, bits [7:3] (5-bit reference divide count), bit [8] (reference doubler) and bits [12:9] (current setting). A write to register 1 or register 2 stores these fields but leaves their active values unchanged.
- R7: A write to register 0 moves every staged field into its active register in the same cycle that register 0 itself is loaded.
- R8: The fractional output equals {active register 0 bits [14:3], active register 1 bits [15:3]}, a 25-bit value.
- R9: Reset (rst_n low) clears all active and staged registers and the shift register to zero.
- R10: A load strobe after fewer than 32 serial clocks commits the shift register as it stands, with older bits still in the upper positions. No bit count is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Asynchronous serial clock |
| ser_dat_i | input | 1 | Asynchronous serial data, MSB first |
| ser_load_i | input | 1 | Asynchronous load strobe, commits on rising edge |
| reg0_o | output | 32 | Active register 0 |
| reg1_o | output | 32 | Active register 1 |
| reg2_o | output | 32 | Active register 2 |
| reg3_o | output | 32 | Active register 3 |
| reg4_o | output | 32 | Active register 4 |
| frac_o | output | 25 | Assembled fractional value |

## Verification
The assertions assume that each serial line stays at one level for at least as many system clocks as the synchronizer chain is deep. They also assume that the serial clock and the load strobe never rise in the same synchronized cycle, so a detected shift and a detected commit never coincide. The stimulus holds every level of data, serial clock and strobe for two to six clocks. It changes data only while the serial clock is low, and it raises the strobe only after the serial clock has been low for several clocks. The reference model is compared on every clock, except in the short window between a strobe rising and the end of its synchronizer latency.

// File: rtl/cfg_regbank_pkg.sv
// Package: shared widths and the staged-field layout of the
// serial configuration register bank.
// Assumes: five registers, code in the low bits of every word.
package cfg_regbank_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_REGS   = 5;
    localparam int CODE_W     = 3;
    localparam int SYNC_DEPTH = 2;

    // Fractional split: high part in register 0, low part in register 1.
    localparam int FRAC_HI_W  = 12;
    localparam int FRAC_LO_W  = 13;
    localparam int FRAC_W     = FRAC_HI_W + FRAC_LO_W;
    localparam int FRAC_LSB   = CODE_W;

    // Register 2 staged fields: count, doubler, current, packed from bit 3.
    localparam int RCNT_W     = 5;
    localparam int DBL_W      = 1;
    localparam int CUR_W      = 4;
    localparam int R2_STG_W   = RCNT_W + DBL_W + CUR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CODE_W-1:0] code_t;

    // Purpose: return a contiguous bit mask of width w starting at lsb.
    function automatic word_t field_mask(input int w, input int lsb);
        word_t m;
        m = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (b >= lsb && b < lsb + w) m[b] = 1'b1;
        end
        return m;
    endfunction

    // Purpose: staged-bit mask for register idx (zero where nothing is staged).
    function automatic word_t stage_mask(input int idx);
        case (idx)
            1:       return field_mask(FRAC_LO_W, FRAC_LSB);
            2:       return field_mask(R2_STG_W, FRAC_LSB);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/cfg_edge_sync.sv
// Module: synchronizes one asynchronous line into clk and reports
// its level and its rising edge, both taken from the same stage.
// Assumes: the line holds each level for at least DEPTH clocks.
module cfg_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [DEPTH:0] chain;

    // Purpose: shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-1:0], async_i};
    end

    assign level_o = chain[DEPTH-1];
    assign rise_o  = chain[DEPTH-1] & ~chain[DEPTH];
endmodule

// File: rtl/cfg_shift_in.sv
// Module: serial-in shift register, new bit enters at bit 0.
// Assumes: shift_en is a single-cycle pulse per serial clock edge.
module cfg_shift_in #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Purpose: move the word up one place and take in the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (shift_en) word_o <= {word_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: five active registers with staged fields. A commit to
// register k>0 applies its unstaged bits at once and parks its staged
// bits. A commit to register 0 loads it and applies all parked bits.
// Assumes: commit is a single-cycle pulse; word is stable with it.
module cfg_reg_bank
    import cfg_regbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  word_t                     word,
    output logic [NUM_REGS-1:0][WORD_W-1:0] act_o
);
    code_t               code;
    logic [NUM_REGS-1:0] wr;

    assign code = word[CODE_W-1:0];

    // Purpose: one-hot write select; codes above the bank are dropped.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wr[i] = commit && (code == CODE_W'(i));
        end
    end

    // Purpose: register 0 is loaded whole on its own write.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_o[0] <= '0;
        else if (wr[0]) act_o[0] <= word;
    end

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        localparam word_t SMASK = stage_mask(g);
        word_t stg;

        // Purpose: split a write into immediate bits and parked bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_o[g] <= '0;
                stg      <= '0;
            end else if (wr[g]) begin
                act_o[g] <= (act_o[g] & SMASK) | (word & ~SMASK);
                stg      <= word & SMASK;
            end else if (wr[0]) begin
                act_o[g] <= (act_o[g] & ~SMASK) | (stg & SMASK);
            end
        end
    end
endmodule

// File: rtl/cfg_serial_regbank.sv
// Module: top of the serial configuration register bank. Synchronizes
// the three serial lines, shifts on serial clock edges, commits on
// load strobe edges and assembles the 25-bit fractional value.
// Assumes: serial clock and strobe never rise in the same cycle.
module cfg_serial_regbank
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_load_i,
    output logic [31:0]       reg0_o,
    output logic [31:0]       reg1_o,
    output logic [31:0]       reg2_o,
    output logic [31:0]       reg3_o,
    output logic [31:0]       reg4_o,
    output logic [24:0]       frac_o
);
    logic  sclk_lvl, sclk_rise;
    logic  dat_lvl, dat_rise;
    logic  load_lvl, load_rise;
    word_t shreg;
    logic [NUM_REGS-1:0][WORD_W-1:0] act;

    cfg_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i),
        .level_o(sclk_lvl), .rise_o(sclk_rise));

    cfg_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .async_i(ser_dat_i),
        .level_o(dat_lvl), .rise_o(dat_rise));

    cfg_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync_load (
        .clk(clk), .rst_n(rst_n), .async_i(ser_load_i),
        .level_o(load_lvl), .rise_o(load_rise));

    cfg_shift_in #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
        .bit_i(dat_lvl), .word_o(shreg));

    cfg_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .commit(load_rise),
        .word(shreg), .act_o(act));

    // Purpose: drive the active words and the joined fractional value.
    always_comb begin
        reg0_o = act[0];
        reg1_o = act[1];
        reg2_o = act[2];
        reg3_o = act[3];
        reg4_o = act[4];
        frac_o = {act[0][FRAC_LSB+FRAC_HI_W-1:FRAC_LSB],
                  act[1][FRAC_LSB+FRAC_LO_W-1:FRAC_LSB]};
    end

    // Unused observation signals kept visible to the checker.
    logic unused_ok;
    assign unused_ok = &{1'b0, sclk_lvl, dat_rise, load_lvl};
endmodule

// File: rtl/cfg_regbank_chk.sv
// Module: assertion checker for cfg_serial_regbank, bound to the top.
// Assumes: shift and commit pulses never coincide.
module cfg_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        shift,
    input logic        din,
    input logic        commit,
    input logic [31:0] word,
    input logic [31:0] r0,
    input logic [31:0] r1,
    input logic [31:0] r2,
    input logic [31:0] r3,
    input logic [31:0] r4
);
    localparam logic [31:0] M1 = 32'h0000_FFF8;
    localparam logic [31:0] M2 = 32'h0000_1FF8;

    // R1: shift moves the word up and takes the data bit at bit 0.
    p_shift_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (word == {$past(word[30:0]), $past(din)}));

    // R2: without a commit no active register changes.
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3) && $stable(r4)));

    // R3: codes 5 to 7 leave the bank untouched.
    p_ignore_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[2:0] > 3'd4) |=>
        ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3) && $stable(r4)));

    // R4: register 0 takes the whole word.
    p_load_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[2:0] == 3'd0) |=> (r0 == $past(word)));

    // R5: unstaged bits of register 1 apply at once.
    p_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[2:0] == 3'd1) |=> ((r1 & ~M1) == ($past(word) & ~M1)));

    // R6: staged bits of registers 1 and 2 hold on their own writes.
    p_stage_hold1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[2:0] == 3'd1) |=> ((r1 & M1) == ($past(r1) & M1)));
    p_stage_hold2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[2:0] == 3'd2) |=> ((r2 & M2) == ($past(r2) & M2)));

    // R9: everything reads zero when reset is released.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r0 == 0 && r1 == 0 && r2 == 0 && r3 == 0 && r4 == 0 && word == 0));
endmodule

bind cfg_serial_regbank cfg_regbank_chk chk_i (
    .clk(clk), .rst_n(rst_n), .shift(sclk_rise), .din(dat_lvl),
    .commit(load_rise), .word(shreg),
    .r0(reg0_o), .r1(reg1_o), .r2(reg2_o), .r3(reg3_o), .r4(reg4_o));

// File: tb/cfg_serial_regbank_tb.sv
// Bench: behavioural reference model of the bank, compared on every
// clock outside commit latency windows, plus named directed checks.
module cfg_serial_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdat = 1'b0, sload = 1'b0;
    logic [31:0] r0, r1, r2, r3, r4;
    logic [24:0] frac;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    logic [31:0] m_sh;
    logic [31:0] m_act [5];
    logic [31:0] m_stg [5];

    always #4 clk = ~clk;

    cfg_serial_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_load_i(sload), .reg0_o(r0), .reg1_o(r1), .reg2_o(r2),
        .reg3_o(r3), .reg4_o(r4), .frac_o(frac));

    function automatic logic [31:0] smask(input int i);
        if (i == 1) return 32'h0000_FFF8;
        if (i == 2) return 32'h0000_1FF8;
        return 32'h0;
    endfunction

    function automatic logic [31:0] dut_reg(input int i);
        case (i)
            0: return r0;
            1: return r1;
            2: return r2;
            3: return r3;
            default: return r4;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // R8 expected value of the fractional output from the model.
    function automatic logic [24:0] m_frac();
        return {m_act[0][14:3], m_act[1][15:3]};
    endfunction

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int i = 0; i < 5; i++)
                chk($sformatf("R5 model reg%0d", i), dut_reg(i), m_act[i]);
            chk("R8 model frac", {7'd0, frac}, {7'd0, m_frac()});
        end
    end

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            sdat = v[k];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            m_sh = {m_sh[30:0], v[k]};
        end
    endtask

    task automatic model_commit();
        int c;
        c = int'(m_sh[2:0]);
        if (c == 0) begin
            m_act[0] = m_sh;
            for (int i = 1; i < 5; i++)
                m_act[i] = (m_act[i] & ~smask(i)) | m_stg[i];
        end else if (c < 5) begin
            m_act[c] = (m_act[c] & smask(c)) | (m_sh & ~smask(c));
            m_stg[c] = m_sh & smask(c);
        end
    endtask

    task automatic strobe();
        cmp_en = 1'b0;
        repeat (2) @(negedge clk);
        sload = 1'b1;
        repeat (6) @(negedge clk);
        model_commit();
        cmp_en = 1'b1;
        sload = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] v);
        send_bits(v, 32);
        strobe();
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual hung expected finished");
            summary();
        end
    end

    initial begin
        m_sh = '0;
        for (int i = 0; i < 5; i++) begin
            m_act[i] = '0;
            m_stg[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        for (int i = 0; i < 5; i++) chk("R9 reset reg", dut_reg(i), 32'h0);
        chk("R9 reset frac", {7'd0, frac}, 32'h0);
        cmp_en = 1'b1;

        // R4 and R1: register 0 loaded whole, order proves MSB first.
        write_word(32'hA5C3_7E18);
        chk("R4 reg0 whole word", r0, 32'hA5C3_7E18);
        chk("R1 msb first", {31'd0, r0[31]}, 32'h1);

        // R5: registers 3 and 4 are immediate.
        write_word(32'h1234_5673);
        write_word(32'hCAFE_BAB4);
        chk("R5 reg3 immediate", r3, 32'h1234_5673);
        chk("R5 reg4 immediate", r4, 32'hCAFE_BAB4);

        // R6: register 1 staged low fraction does not show yet.
        write_word(32'hF00F_5551);
        chk("R5 reg1 unstaged bits", r1 & ~32'h0000_FFF8, 32'hF00F_0001);
        chk("R6 reg1 staged held", r1 & 32'h0000_FFF8, 32'h0);
        chk("R6 frac low unchanged", {19'd0, frac[12:0]}, 32'h0);

        // R6: register 2 staged count, doubler, current.
        write_word(32'h8000_1FFA);
        chk("R6 reg2 staged held", r2 & 32'h0000_1FF8, 32'h0);
        chk("R5 reg2 unstaged bits", r2 & ~32'h0000_1FF8, 32'h8000_0002);

        // R7 and R8: register 0 write applies all staged fields at once.
        write_word(32'h0000_7FF8);
        chk("R7 reg1 staged applied", r1, 32'hF00F_5551);
        chk("R7 reg2 staged applied", r2, 32'h8000_1FFA);
        chk("R8 frac joined", {7'd0, frac}, {7'd0, 12'hFFF, 13'h0AAA});

        // R3: codes 5, 6 and 7 change nothing.
        write_word(32'hFFFF_FFFD);
        write_word(32'h1111_1116);
        write_word(32'h2222_2227);
        chk("R3 reg0 untouched", r0, 32'h0000_7FF8);
        chk("R3 reg4 untouched", r4, 32'hCAFE_BAB4);

        // R10: short word keeps older bits above the new ones.
        send_bits(32'h0000_00E3, 8);
        strobe();
        chk("R10 short word reg3", r3, 32'h2222_27E3);

        // R2: shifting alone leaves outputs alone.
        send_bits(32'h0000_00F0, 8);
        chk("R2 no change while shifting", r3, 32'h2222_27E3);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule